// File: doc/BRIEF.md
# Multi-Channel Interrupt Multiplexer

This block routes 32 level-sensitive, active-high interrupt sources to eight independent output lines. Every output channel sees all 32 sources. Each channel keeps its own enable mask, so software can steer any source to any subset of the outputs. A source reaches a channel's pending status only while its bit in that channel's mask is set. The channel's single output line is raised while any of its pending bits is set.

Software reaches the block through a small synchronous register port. It drives an address, a write strobe and write data, and it sees read data combinationally for the address it presents. Each channel has a writable enable register and a read-only pending register, and the channels are laid out at a 64-byte stride. Sources may come from other clock domains, so each one passes through a two-stage synchronizer before use.

The register decoder classifies each bus address as one of three kinds: `REG_NONE` for an unmapped address, `REG_ENABLE`, or `REG_PENDING`. No sequencing state machine is involved.

Top module: `irq_router`

## Requirements
- R1: After reset, every enable register reads 0, every pending register reads 0 and every `irq_out` bit is 0.
- R2: The enable register of channel n sits at byte address 0x10 + 0x40*n. A write there stores all 32 bits, and a read returns exactly the value last written.
- R3: The pending register of channel n sits at byte address 0x20 + 0x40*n. Its bit k reads 1 exactly when synchronized source k is high and enable bit k of channel n is 1.
- R4: Pending bits follow the source level and are never latched. When a source drops, its pending bit clears once the drop has passed through the synchronizer.
- R5: `irq_out[n]` is the OR of channel n's 32 pending bits, delayed by one register stage. A source change therefore shows on the output three rising edges after it is applied.
- R6: Writing 0 to a channel's enable register masks every source of that channel. Its pending register then reads 0, and its output is low by the second rising edge after the write.
- R7: A write to one channel's enable register changes no other channel's enable register, pending register or output.
- R8: Writes to a pending register address are ignored. Enable registers and outputs are left unchanged.
- R9: Reads from unmapped addresses return 0, and writes to them change nothing. Unmapped addresses are any offset other than 0x10 or 0x20 within a 64-byte channel slot, and any slot at channel index 8 or higher.
- R10: A source change appears in the pending registers two rising edges after it is applied, and not after only one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Level interrupt sources, active high, may be asynchronous |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 8 | One registered interrupt line per channel |

## Verification
A corrupted enable register shows up right away on a readback of its own address. It also shows two edges after any source change as a wrong pending bit, and one edge after that as a wrong output level. A decode fault that aliases an unmapped or pending address onto an enable register shows on the very next read of the aliased channel. A synchronizer with the wrong depth shows up as pending data that arrives one edge early or one edge late. The bench samples at the exact edge counts to catch this.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    // Kind of register selected by a bus address.
    typedef enum logic [1:0] {
        REG_NONE    = 2'd0,
        REG_ENABLE  = 2'd1,
        REG_PENDING = 2'd2
    } reg_kind_e;

    // Each channel owns a 64-byte slot; the low bits pick the register.
    localparam int SLOT_LG = 6;
    localparam logic [SLOT_LG-1:0] OFS_ENABLE  = 6'h10;
    localparam logic [SLOT_LG-1:0] OFS_PENDING = 6'h20;

endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // Counts the edges since reset, so the latency check only looks at history it has.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R10: the output equals the input as it was two edges earlier
    a_r10_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/irqr_regdec.sv
module irqr_regdec
    import irqr_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr_en,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  en_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  pend_all,
    output logic [NUM_CH-1:0]              en_wr_stb,
    output logic [DATA_W-1:0]              rdata
);

    localparam int IDX_W = ADDR_W - SLOT_LG;

    logic [IDX_W-1:0]   slot_idx;
    logic [SLOT_LG-1:0] slot_ofs;
    logic               slot_valid;
    reg_kind_e          kind;

    assign slot_idx   = addr[ADDR_W-1:SLOT_LG];
    assign slot_ofs   = addr[SLOT_LG-1:0];
    assign slot_valid = (int'(slot_idx) < NUM_CH);

    always_comb begin
        kind = REG_NONE;
        if (slot_valid) begin
            unique case (slot_ofs)
                OFS_ENABLE:  kind = REG_ENABLE;
                OFS_PENDING: kind = REG_PENDING;
                default:     kind = REG_NONE;
            endcase
        end
    end

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_stb
            assign en_wr_stb[gc] = wr_en && (kind == REG_ENABLE) && (int'(slot_idx) == gc);
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(slot_idx) == c) begin
                unique case (kind)
                    REG_ENABLE:  rdata = en_all[c];
                    REG_PENDING: rdata = pend_all[c];
                    default:     rdata = '0;
                endcase
            end
        end
    end

    // R9: unmapped addresses never read nonzero
    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_valid || ((slot_ofs != OFS_ENABLE) && (slot_ofs != OFS_PENDING))) |-> (rdata == '0));

    // R7: at most one enable register is written per cycle
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_wr_stb));

    // R8: a write to a pending address strobes no enable register
    a_r8_pending_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot_valid && (slot_ofs == OFS_PENDING)) |-> (en_wr_stb == '0));

endmodule

// File: rtl/irqr_channel.sv
module irqr_channel #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic [NUM_SRC-1:0] src_sync,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] pend,
    output logic               irq_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_stb) en_q <= wr_data;
    end

    assign pend = src_sync & en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend;
    end

    // R2: a write stores the full data word
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (en_q == $past(wr_data)));

    // R7: without a strobe the enable register holds its value
    a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(en_q));

    // R5: the output can only be high if some enable bit was set an edge earlier
    a_r5_out_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(en_q) != '0));

    // R6: after a write of zero, the output is low two edges later
    a_r6_zero_clears_out: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (wr_data == '0)) |=> ##1 !irq_q);

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irqr_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr_en,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic [NUM_CH-1:0]  irq_out
);

    localparam int DATA_W = NUM_SRC;

    logic [NUM_SRC-1:0]               src_sync;
    logic [NUM_CH-1:0][DATA_W-1:0]    en_all;
    logic [NUM_CH-1:0][DATA_W-1:0]    pend_all;
    logic [NUM_CH-1:0]                en_wr_stb;

    irqr_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_in),
        .sync_out (src_sync)
    );

    irqr_regdec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr_en     (bus_wr_en),
        .en_all    (en_all),
        .pend_all  (pend_all),
        .en_wr_stb (en_wr_stb),
        .rdata     (bus_rdata)
    );

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
            irqr_channel #(.NUM_SRC(NUM_SRC)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_stb   (en_wr_stb[gc]),
                .wr_data  (bus_wdata),
                .src_sync (src_sync),
                .en_q     (en_all[gc]),
                .pend     (pend_all[gc]),
                .irq_q    (irq_out[gc])
            );
        end
    endgenerate

    // R1: during reset every output line is low one edge later
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq_out == '0));

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;

    localparam int NCH = 8;
    localparam int NSRC = 32;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_in = '0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr_en = 1'b0;
    logic [NSRC-1:0] bus_wdata = '0;
    logic [NSRC-1:0] bus_rdata;
    logic [NCH-1:0]  irq_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [NSRC-1:0] en_m [NCH];

    always #4 clk = ~clk;

    irq_router #(.NUM_CH(NCH), .NUM_SRC(NSRC), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [AW-1:0] en_addr(int ch);
        return AW'(16 + 64 * ch);
    endfunction
    function automatic logic [AW-1:0] pd_addr(int ch);
        return AW'(32 + 64 * ch);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [NSRC-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [NSRC-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_src(logic [NSRC-1:0] v);
        @(negedge clk);
        src_in = v;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] exp_irq(logic [NSRC-1:0] s);
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = |(s & en_m[c]);
        return r;
    endfunction

    task automatic check_all(string req);
        logic [NSRC-1:0] d;
        for (int c = 0; c < NCH; c++) begin
            rd(pd_addr(c), d);
            chk(req, d, src_in & en_m[c]);
            rd(en_addr(c), d);
            chk(req, d, en_m[c]);
        end
        chk(req, 32'(irq_out), 32'(exp_irq(src_in)));
    endtask

    task automatic t_reset;
        src_in = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        check_all("R1");
        chk("R1 irq", 32'(irq_out), 32'h0);
    endtask

    task automatic t_readback;
        logic [NSRC-1:0] d;
        for (int c = 0; c < NCH; c++) begin
            en_m[c] = 32'hA5C3_0000 ^ (32'h1 << c) ^ (32'h0101_0101 * c);
            wr(en_addr(c), en_m[c]);
        end
        for (int c = 0; c < NCH; c++) begin
            rd(en_addr(c), d);
            chk("R2", d, en_m[c]);
        end
    endtask

    task automatic t_patterns;
        logic [NSRC-1:0] pats [4];
        pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0000;
        pats[2] = 32'h1234_5678; pats[3] = 32'hFFFF_FFFF;
        for (int p = 0; p < 4; p++) begin
            set_src(pats[p]);
            check_all("R3 R5");
        end
    endtask

    task automatic t_level;
        set_src(32'hFFFF_FFFF);
        check_all("R4 high");
        set_src(32'h0);
        check_all("R4 drop");
        chk("R4 irq", 32'(irq_out), 32'h0);
    endtask

    task automatic t_latency;
        logic [NSRC-1:0] d;
        en_m[2] = 32'h0000_0010;
        wr(en_addr(2), en_m[2]);
        set_src(32'h0);
        bus_addr = pd_addr(2);
        @(negedge clk);
        src_in = 32'h0000_0010;
        @(posedge clk); @(negedge clk);
        rd(pd_addr(2), d);
        chk("R10 one edge", d, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(pd_addr(2), d);
        chk("R10 two edges", d, 32'h0000_0010);
        chk("R5 not yet", 32'(irq_out[2]), 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R5 three edges", 32'(irq_out[2]), 32'h1);
    endtask

    task automatic t_independent;
        en_m[3] = 32'h0000_F0F0;
        wr(en_addr(3), en_m[3]);
        set_src(32'h0000_00F0);
        check_all("R7");
        en_m[5] = 32'h0;
        wr(en_addr(5), 32'h0);
        check_all("R7 after");
    endtask

    task automatic t_zero;
        set_src(32'hFFFF_FFFF);
        en_m[6] = 32'h0;
        @(negedge clk);
        bus_addr = en_addr(6); bus_wdata = '0; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        @(negedge clk);
        chk("R6 out low", 32'(irq_out[6]), 32'h0);
        check_all("R6");
    endtask

    task automatic t_pending_write;
        wr(pd_addr(1), 32'hFFFF_FFFF);
        wr(pd_addr(4), 32'h0);
        repeat (2) @(negedge clk);
        check_all("R8");
    endtask

    task automatic t_unmapped;
        logic [NSRC-1:0] d;
        wr(AW'(16 + 64 * 9), 32'hDEAD_BEEF);
        wr(AW'(32 + 64 * 12), 32'hDEAD_BEEF);
        wr(AW'(20), 32'hDEAD_BEEF);
        wr(AW'(64 + 8), 32'hDEAD_BEEF);
        wr(AW'(64 * 63 + 16), 32'hDEAD_BEEF);
        repeat (2) @(negedge clk);
        check_all("R9 write");
        rd(AW'(16 + 64 * 9), d);  chk("R9 read slot9", d, 32'h0);
        rd(AW'(32 + 64 * 8), d);  chk("R9 read slot8", d, 32'h0);
        rd(AW'(20), d);           chk("R9 read ofs14", d, 32'h0);
        rd(AW'(0), d);            chk("R9 read ofs0", d, 32'h0);
        rd(AW'(64 * 3 + 48), d);  chk("R9 read ofs30", d, 32'h0);
    endtask

    bit done = 0;

    initial begin
        for (int c = 0; c < NCH; c++) en_m[c] = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        src_in = '0;
        repeat (3) @(negedge clk);
        check_all("R1 after release");
        t_readback;
        t_patterns;
        t_level;
        t_latency;
        t_independent;
        t_zero;
        t_pending_write;
        t_unmapped;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule